// File: doc/BRIEF.md
# Overflow Metadata Conflict Checker

This block judges one coherence access against the persistent per-block metadata kept for the single overflowed transaction that may run at a time. The metadata has a read bit, a write bit and the identifier of the overflowed transaction that set them. The caller supplies the access kind, whether the requester is the overflowed transaction itself, the block's ownership state, the stored metadata, and the shared overflow flag with the current overflowed transaction identifier. The block returns a conflict verdict, the metadata to deliver with the block, and whether that metadata may be written back into the block.

Stale metadata is never cleared explicitly. A stored entry counts only when the shared overflow flag is set and its identifier equals the current one. When the overflowed transaction touches a block holding stale metadata, the block replaces the identifier and clears the bit that is not being set. Only a block owner, in the owned or exclusive state, may change metadata, so an out-of-order writeback cannot put older metadata over newer. The same access path marks the blocks already cached when a transaction enters overflow mode.

A small state machine runs each request. `ST_IDLE` accepts a request when `req_valid` is high (transition accept). `ST_EVAL` judges the captured request and registers the result (transition judge). `ST_REPLY` presents the result for one cycle (transition release) and then returns to `ST_IDLE`. Reset forces `ST_IDLE`.

Top module: `ovf_meta_checker`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0, and every result output is 0.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both 1. `rsp_valid` is 1 for exactly the single cycle that starts on the second rising edge after acceptance. `req_ready` is 0 from the edge after acceptance until `rsp_valid` falls.
- R3: Stored metadata is current only when `ovf_active` is 1 and `meta_id_in` equals `ovf_id`. Stale metadata never produces a conflict.
- R4: A read (`req_write`=0) from a requester other than the overflowed transaction conflicts exactly when the current write bit is set.
- R5: A write (`req_write`=1) from a requester other than the overflowed transaction conflicts exactly when the current read bit or the current write bit is set.
- R6: An access from the overflowed transaction (`req_from_ovf`=1 while `ovf_active`=1) never conflicts.
- R7: An access from the overflowed transaction to an owned block (`blk_state` 2 = owned, 3 = exclusive) on current metadata returns `rsp_meta_we`=1. A read sets the read bit and a write sets the write bit. The other bit and the identifier are kept.
- R8: The same update on stale metadata stores `ovf_id` as the identifier, sets the requested bit and clears the other bit.
- R9: An update asked for on a non-owned block (`blk_state` 0 = invalid, 1 = shared) is refused. The block returns `rsp_refused`=1 and `rsp_meta_we`=0, and the returned metadata equals the stored metadata.
- R10: When no update is asked for, the returned metadata equals the stored metadata, with `rsp_meta_we`=0 and `rsp_refused`=0.
- R11: While `ovf_active` is 0, a request with `req_from_ovf`=1 causes no update and no conflict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_from_ovf | input | 1 | Requester is the overflowed transaction |
| blk_state | input | 2 | 0 invalid, 1 shared, 2 owned, 3 exclusive |
| meta_rd_in | input | 1 | Stored read bit |
| meta_wr_in | input | 1 | Stored write bit |
| meta_id_in | input | ID_W | Stored transaction identifier |
| ovf_active | input | 1 | Shared overflow flag |
| ovf_id | input | ID_W | Current overflowed transaction identifier |
| rsp_valid | output | 1 | Result present |
| rsp_conflict | output | 1 | Access conflicts with the overflowed transaction |
| rsp_meta_rd | output | 1 | Returned read bit |
| rsp_meta_wr | output | 1 | Returned write bit |
| rsp_meta_id | output | ID_W | Returned identifier |
| rsp_meta_we | output | 1 | Returned metadata may be written to the block |
| rsp_refused | output | 1 | Update asked for by a non-owner and refused |

## Verification
A wrong state register shows up as a missing, doubled or early `rsp_valid`, or as `req_ready` staying low. The scoreboard ties each result to its request and to its expected cycle, so this is reported within two cycles of the request. A wrong capture or judge register gives a wrong conflict verdict or wrong metadata in that same response. The bench sweeps every combination of access kind, requester, ownership, stored bits, identifier match and overflow flag, so each path is compared at the first response that uses it.

// File: rtl/ovf_meta_pkg.sv
package ovf_meta_pkg;

    typedef enum logic [1:0] {
        BLK_INVALID   = 2'd0,
        BLK_SHARED    = 2'd1,
        BLK_OWNED     = 2'd2,
        BLK_EXCLUSIVE = 2'd3
    } blk_state_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EVAL  = 2'd1,
        ST_REPLY = 2'd2
    } fsm_e;

    function automatic logic holds_block(input blk_state_e s);
        return (s == BLK_OWNED) || (s == BLK_EXCLUSIVE);
    endfunction

endpackage

// File: rtl/ovf_meta_judge.sv
module ovf_meta_judge #(
    parameter int ID_W = 8
) (
    input  logic            acc_write,
    input  logic            acc_from_ovf,
    input  logic            st_rd,
    input  logic            st_wr,
    input  logic [ID_W-1:0] st_id,
    input  logic            act,
    input  logic [ID_W-1:0] act_id,
    output logic            is_current,
    output logic            conflict
);
    logic hit;

    always_comb begin
        is_current = act && (st_id == act_id);
        hit        = acc_write ? (st_rd || st_wr) : st_wr;
        conflict   = is_current && !acc_from_ovf && hit;
    end
endmodule

// File: rtl/ovf_meta_writer.sv
module ovf_meta_writer #(
    parameter int ID_W = 8
) (
    input  logic                    acc_write,
    input  logic                    acc_from_ovf,
    input  ovf_meta_pkg::blk_state_e bstate,
    input  logic                    st_rd,
    input  logic                    st_wr,
    input  logic [ID_W-1:0]         st_id,
    input  logic                    act,
    input  logic [ID_W-1:0]         act_id,
    input  logic                    is_current,
    output logic                    out_rd,
    output logic                    out_wr,
    output logic [ID_W-1:0]         out_id,
    output logic                    we,
    output logic                    refused
);
    logic want;
    logic owner;

    always_comb begin
        want    = acc_from_ovf && act;
        owner   = ovf_meta_pkg::holds_block(bstate);
        we      = want && owner;
        refused = want && !owner;
        out_rd  = st_rd;
        out_wr  = st_wr;
        out_id  = st_id;
        if (we) begin
            out_id = act_id;
            out_rd = acc_write ? (is_current && st_rd) : 1'b1;
            out_wr = acc_write ? 1'b1 : (is_current && st_wr);
        end
    end
endmodule

// File: rtl/ovf_meta_checker.sv
module ovf_meta_checker #(
    parameter int ID_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic            req_write,
    input  logic            req_from_ovf,
    input  logic [1:0]      blk_state,
    input  logic            meta_rd_in,
    input  logic            meta_wr_in,
    input  logic [ID_W-1:0] meta_id_in,
    input  logic            ovf_active,
    input  logic [ID_W-1:0] ovf_id,
    output logic            rsp_valid,
    output logic            rsp_conflict,
    output logic            rsp_meta_rd,
    output logic            rsp_meta_wr,
    output logic [ID_W-1:0] rsp_meta_id,
    output logic            rsp_meta_we,
    output logic            rsp_refused
);
    import ovf_meta_pkg::*;

    typedef struct packed {
        logic            wr_acc;
        logic            from_ovf;
        blk_state_e      bstate;
        logic            rd;
        logic            wr;
        logic [ID_W-1:0] id;
        logic            act;
        logic [ID_W-1:0] act_id;
    } req_t;

    typedef struct packed {
        logic            conflict;
        logic            rd;
        logic            wr;
        logic [ID_W-1:0] id;
        logic            we;
        logic            refused;
    } res_t;

    fsm_e st_q, st_d;
    req_t cap_q;
    res_t res_q, res_d;
    logic cur;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // transitions: accept, judge, release
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (req_valid) st_d = ST_EVAL;
            ST_EVAL:  st_d = ST_REPLY;
            ST_REPLY: st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else if (st_q == ST_IDLE && req_valid) begin
            cap_q.wr_acc   <= req_write;
            cap_q.from_ovf <= req_from_ovf;
            cap_q.bstate   <= blk_state_e'(blk_state);
            cap_q.rd       <= meta_rd_in;
            cap_q.wr       <= meta_wr_in;
            cap_q.id       <= meta_id_in;
            cap_q.act      <= ovf_active;
            cap_q.act_id   <= ovf_id;
        end
    end

    ovf_meta_judge #(.ID_W(ID_W)) u_judge (
        .acc_write    (cap_q.wr_acc),
        .acc_from_ovf (cap_q.from_ovf),
        .st_rd        (cap_q.rd),
        .st_wr        (cap_q.wr),
        .st_id        (cap_q.id),
        .act          (cap_q.act),
        .act_id       (cap_q.act_id),
        .is_current   (cur),
        .conflict     (res_d.conflict)
    );

    ovf_meta_writer #(.ID_W(ID_W)) u_writer (
        .acc_write    (cap_q.wr_acc),
        .acc_from_ovf (cap_q.from_ovf),
        .bstate       (cap_q.bstate),
        .st_rd        (cap_q.rd),
        .st_wr        (cap_q.wr),
        .st_id        (cap_q.id),
        .act          (cap_q.act),
        .act_id       (cap_q.act_id),
        .is_current   (cur),
        .out_rd       (res_d.rd),
        .out_wr       (res_d.wr),
        .out_id       (res_d.id),
        .we           (res_d.we),
        .refused      (res_d.refused)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)                res_q <= '0;
        else if (st_q == ST_EVAL)  res_q <= res_d;
    end

    // outputs
    always_comb begin
        req_ready    = (st_q == ST_IDLE);
        rsp_valid    = (st_q == ST_REPLY);
        rsp_conflict = res_q.conflict;
        rsp_meta_rd  = res_q.rd;
        rsp_meta_wr  = res_q.wr;
        rsp_meta_id  = res_q.id;
        rsp_meta_we  = res_q.we;
        rsp_refused  = res_q.refused;
    end
endmodule

// File: rtl/ovf_meta_checker_sva.sv
module ovf_meta_checker_sva #(
    parameter int ID_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic            req_from_ovf,
    input logic            ovf_active,
    input logic [ID_W-1:0] ovf_id,
    input logic            rsp_valid,
    input logic            rsp_conflict,
    input logic [ID_W-1:0] rsp_meta_id,
    input logic            rsp_meta_we,
    input logic            rsp_refused
);
    a_r2_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r2_two_edges: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> ##1 rsp_valid);

    a_r2_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    a_r9_refuse_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_refused) |-> !rsp_meta_we);

    a_r6_self_no_conflict: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(req_from_ovf, 2) && $past(ovf_active, 2)) |-> !rsp_conflict);

    a_r3_inactive_no_conflict: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !$past(ovf_active, 2)) |-> !rsp_conflict);

    a_r8_write_takes_id: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_meta_we) |-> (rsp_meta_id == $past(ovf_id, 2)));
endmodule

bind ovf_meta_checker ovf_meta_checker_sva #(.ID_W(ID_W)) u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_from_ovf (req_from_ovf),
    .ovf_active   (ovf_active),
    .ovf_id       (ovf_id),
    .rsp_valid    (rsp_valid),
    .rsp_conflict (rsp_conflict),
    .rsp_meta_id  (rsp_meta_id),
    .rsp_meta_we  (rsp_meta_we),
    .rsp_refused  (rsp_refused)
);

// File: tb/test_ovf_meta_checker.sv
module test_ovf_meta_checker;
    localparam int ID_W = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic            req_write = 1'b0;
    logic            req_from_ovf = 1'b0;
    logic [1:0]      blk_state = 2'd0;
    logic            meta_rd_in = 1'b0;
    logic            meta_wr_in = 1'b0;
    logic [ID_W-1:0] meta_id_in = '0;
    logic            ovf_active = 1'b0;
    logic [ID_W-1:0] ovf_id = '0;
    logic            rsp_valid;
    logic            rsp_conflict;
    logic            rsp_meta_rd;
    logic            rsp_meta_wr;
    logic [ID_W-1:0] rsp_meta_id;
    logic            rsp_meta_we;
    logic            rsp_refused;

    ovf_meta_checker #(.ID_W(ID_W)) i_ovf_meta_checker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_from_ovf(req_from_ovf), .blk_state(blk_state),
        .meta_rd_in(meta_rd_in), .meta_wr_in(meta_wr_in), .meta_id_in(meta_id_in),
        .ovf_active(ovf_active), .ovf_id(ovf_id), .rsp_valid(rsp_valid),
        .rsp_conflict(rsp_conflict), .rsp_meta_rd(rsp_meta_rd), .rsp_meta_wr(rsp_meta_wr),
        .rsp_meta_id(rsp_meta_id), .rsp_meta_we(rsp_meta_we), .rsp_refused(rsp_refused)
    );

    always #5 clk = ~clk;

    typedef struct {
        logic            conflict;
        logic            rd;
        logic            wr;
        logic [ID_W-1:0] id;
        logic            we;
        logic            refused;
        int              due;
        string           tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // expected result, written from the requirements
    function automatic exp_t model(input bit w, input bit fo, input logic [1:0] bs,
                                   input bit rd, input bit wr, input logic [ID_W-1:0] sid,
                                   input bit act, input logic [ID_W-1:0] aid);
        exp_t e;
        bit cur, upd, own;
        cur = act && (sid == aid);
        upd = fo && act;
        own = (bs == 2'd2) || (bs == 2'd3);
        e.conflict = 1'b0; e.we = 1'b0; e.refused = 1'b0;
        e.rd = rd; e.wr = wr; e.id = sid; e.due = 0;
        if (upd) begin
            if (own) begin
                e.we = 1'b1; e.id = aid;
                if (w) begin e.wr = 1'b1; e.rd = cur ? rd : 1'b0; end
                else   begin e.rd = 1'b1; e.wr = cur ? wr : 1'b0; end
                e.tag = cur ? "R6/R7" : "R6/R8";
            end else begin
                e.refused = 1'b1;
                e.tag = "R6/R9";
            end
        end else if (fo) begin
            e.tag = "R11/R10";
        end else if (!cur) begin
            e.tag = "R3/R10";
        end else begin
            e.conflict = w ? (rd || wr) : wr;
            e.tag = w ? "R5/R10" : "R4/R10";
        end
        return e;
    endfunction

    // driver: hand one request to the block, push its expected item
    task automatic send(input bit w, input bit fo, input logic [1:0] bs,
                        input bit rd, input bit wr, input logic [ID_W-1:0] sid,
                        input bit act, input logic [ID_W-1:0] aid);
        exp_t e;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = w; req_from_ovf = fo; blk_state = bs;
        meta_rd_in = rd; meta_wr_in = wr; meta_id_in = sid;
        ovf_active = act; ovf_id = aid;
        e = model(w, fo, bs, rd, wr, sid, act, aid);
        e.due = cyc + 2;
        q.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
        check(!req_ready, "R2", "ready after accept", req_ready, 0);
    endtask

    // monitor: compare each response with the head of the queue
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && rsp_valid) begin
                if (q.size() == 0) begin
                    check(1'b0, "R2", "unexpected response", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(cyc == e.due, "R2", "response cycle", cyc, e.due);
                    check(rsp_conflict == e.conflict, e.tag, "conflict", rsp_conflict, e.conflict);
                    check({rsp_meta_rd, rsp_meta_wr, rsp_meta_id} == {e.rd, e.wr, e.id},
                          e.tag, "metadata", {rsp_meta_rd, rsp_meta_wr, rsp_meta_id},
                          {e.rd, e.wr, e.id});
                    check({rsp_meta_we, rsp_refused} == {e.we, e.refused}, e.tag,
                          "we/refused", {rsp_meta_we, rsp_refused}, {e.we, e.refused});
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            check(1'b0, "R2", "watchdog expired", cyc, 0);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [ID_W-1:0] aid;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(req_ready == 1'b1, "R1", "req_ready", req_ready, 1);
        check(rsp_valid == 1'b0, "R1", "rsp_valid", rsp_valid, 0);
        check({rsp_conflict, rsp_meta_rd, rsp_meta_wr, rsp_meta_id, rsp_meta_we, rsp_refused} == '0,
              "R1", "results", {rsp_conflict, rsp_meta_rd, rsp_meta_wr, rsp_meta_id}, 0);
        rst_n = 1'b1;

        // directed corner cases
        send(1, 0, 2'd1, 1, 0, 8'h21, 1, 8'h21);   // R5: write hits current read bit
        send(0, 0, 2'd1, 1, 0, 8'h21, 1, 8'h21);   // R4: read over read bit, no conflict
        send(0, 0, 2'd1, 0, 1, 8'h20, 1, 8'h21);   // R3: stale id, no conflict
        send(0, 1, 2'd3, 0, 1, 8'h21, 1, 8'h21);   // R7: keep write bit, set read
        send(1, 1, 2'd2, 1, 0, 8'h07, 1, 8'h21);   // R8: stale, clear read, take id
        send(1, 1, 2'd1, 1, 1, 8'h07, 1, 8'h21);   // R9: shared owner refused
        send(1, 1, 2'd3, 1, 1, 8'h21, 0, 8'h21);   // R11: flag low

        // sweep of all input combinations
        aid = 8'h30;
        for (int k = 0; k < 256; k++) begin
            logic [ID_W-1:0] sid;
            aid = aid + 8'd3;
            sid = k[7] ? aid : (aid ^ 8'h5A);
            send(k[0], k[1], k[3:2], k[4], k[5], sid, k[6], aid);
        end

        repeat (6) @(negedge clk);
        check(q.size() == 0, "R2", "responses missing", q.size(), 0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule